// File: doc/BRIEF.md
# Warp Issue Scheduler

The block owns one issue port shared by a fixed pool of resident warps. Each warp presents its next instruction with a valid flag. A register scoreboard inside the block marks as pending the destination register of every instruction it issues. A warp may issue only when none of the registers its instruction names is pending. At every free issue slot the block picks one warp among the eligible ones and drives its warp id and instruction word onto the issue port. The port then stays with that instruction for a fixed number of clocks while all lanes of the warp receive it.

The selection rule is oldest first. Each warp has a saturating age counter, and when ages are equal the lower warp index wins. Changing from one warp to another costs no idle cycle. A single writeback port clears one pending register of one warp per cycle. The instruction source advances a warp to its next instruction when it sees beat 0 of that warp on the issue port.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `issue_valid_o` is low, whatever the valid inputs show.
- R2: An instruction word carries its destination register in bits [RW-1:0], source A in [2RW-1:RW] and source B in [3RW-1:2RW], where RW is log2 of the registers per warp (3 by default). A warp whose source A, source B or destination register is pending in its own scoreboard is not issued.
- R3: The cycle that selects a warp sets that warp's destination register pending. A writeback (`wb_valid_i`, `wb_warp_i`, `wb_reg_i`) clears one pending bit, and it already counts toward eligibility in the cycle it is presented.
- R4: When a writeback clears a register in the same cycle that the same warp is selected with that register as destination, the register ends up pending.
- R5: Among eligible warps the one with the largest age is selected. A warp's age counts the consecutive cycles its valid input has been high since it last issued, saturating at 2^AGE_W-1. It returns to 0 when the warp issues or its valid input is low.
- R6: Among eligible warps of equal age, the lowest warp index is selected.
- R7: Each issue holds `issue_valid_o` high for exactly DISPATCH consecutive cycles, with `issue_beat_o` stepping 0 to DISPATCH-1 and warp id and instruction steady.
- R8: If a warp is eligible in the cycle that shows the last beat, beat 0 of the next issue follows in the very next cycle.
- R9: If no warp is eligible in a cycle where the port is free, `issue_valid_o` is low in the next cycle.
- R10: An instruction selected in cycle t appears with beat 0 in cycle t+1, and carries the word and warp id presented in cycle t.
- R11: Pending state is kept per warp. A writeback to one warp leaves every other warp's pending bits untouched, and a register pending in one warp does not block another warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid_i | input | NUM_WARPS | Per-warp next-instruction valid |
| instr_i | input | NUM_WARPS*INSTR_W | Per-warp next instruction word, warp w at [w*INSTR_W +: INSTR_W] |
| wb_valid_i | input | 1 | Writeback strobe |
| wb_warp_i | input | log2(NUM_WARPS) | Warp of the writeback |
| wb_reg_i | input | log2(NUM_REGS) | Register cleared by the writeback |
| issue_valid_o | output | 1 | Issue port busy with an instruction |
| issue_beat_o | output | log2(DISPATCH) | Lane-group beat within the dispatch window |
| issue_warp_o | output | log2(NUM_WARPS) | Warp being issued |
| issue_instr_o | output | INSTR_W | Instruction being issued |

## Verification
The two functions that can land in one cycle are the writeback clearing a register and the selection that sets a register pending. This happens for the same warp and the same register when a warp's destination is still pending and the writeback that releases it arrives while the port is free. The bench arranges this with one warp that issues two instructions to the same destination and then a third that reads it. The writeback releases the second instruction, which must issue at once, and the third must then stall until a later writeback. A reference model of the scoreboard and the age counters predicts every issue, and each observed beat 0 is compared against the next predicted item.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  typedef enum logic {
    PORT_IDLE = 1'b0,
    PORT_BUSY = 1'b1
  } port_state_e;

  // index width for a count of n items, at least one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wsched_scoreboard.sv
module wsched_scoreboard
  import wsched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 16,
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned INSTR_W   = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_WARPS-1:0]           instr_valid_i,
  input  logic [NUM_WARPS*INSTR_W-1:0]   instr_i,
  input  logic                           wb_valid_i,
  input  logic [idx_w(NUM_WARPS)-1:0]    wb_warp_i,
  input  logic [idx_w(NUM_REGS)-1:0]     wb_reg_i,
  input  logic                           set_valid_i,
  input  logic [idx_w(NUM_WARPS)-1:0]    set_warp_i,
  output logic [NUM_WARPS-1:0]           elig_o,
  output logic [NUM_WARPS*NUM_REGS-1:0]  pend_o
);
  localparam int unsigned WIDW = idx_w(NUM_WARPS);
  localparam int unsigned RW   = idx_w(NUM_REGS);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic [NUM_REGS-1:0] pend_q;
    logic [NUM_REGS-1:0] clr_vec;
    logic [NUM_REGS-1:0] set_vec;
    logic [NUM_REGS-1:0] live;
    logic [RW-1:0]       dst_r;
    logic [RW-1:0]       src_a;
    logic [RW-1:0]       src_b;

    assign dst_r = instr_i[w*INSTR_W +: RW];
    assign src_a = instr_i[w*INSTR_W + RW +: RW];
    assign src_b = instr_i[w*INSTR_W + 2*RW +: RW];

    always_comb begin
      clr_vec = '0;
      if (wb_valid_i && (wb_warp_i == WIDW'(w))) clr_vec[wb_reg_i] = 1'b1;
    end

    always_comb begin
      set_vec = '0;
      if (set_valid_i && (set_warp_i == WIDW'(w))) set_vec[dst_r] = 1'b1;
    end

    // a writeback presented this cycle already frees its register
    assign live = pend_q & ~clr_vec;

    assign elig_o[w] = instr_valid_i[w] & ~live[src_a] & ~live[src_b] & ~live[dst_r];

    // the newly issued destination wins over a same-cycle clear
    always_ff @(posedge clk) begin
      if (rst) pend_q <= '0;
      else     pend_q <= live | set_vec;
    end

    assign pend_o[w*NUM_REGS +: NUM_REGS] = pend_q;
  end

endmodule

// File: rtl/wsched_age.sv
module wsched_age
  import wsched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 16,
  parameter int unsigned AGE_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_WARPS-1:0]          instr_valid_i,
  input  logic                          grant_valid_i,
  input  logic [idx_w(NUM_WARPS)-1:0]   grant_warp_i,
  output logic [NUM_WARPS*AGE_W-1:0]    age_o
);
  localparam int unsigned WIDW = idx_w(NUM_WARPS);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_age
    logic [AGE_W-1:0] age_q;
    logic             took;

    assign took = grant_valid_i && (grant_warp_i == WIDW'(w));

    always_ff @(posedge clk) begin
      if (rst)                            age_q <= '0;
      else if (!instr_valid_i[w] || took) age_q <= '0;
      else if (age_q != '1)               age_q <= age_q + 1'b1;
    end

    assign age_o[w*AGE_W +: AGE_W] = age_q;
  end

endmodule

// File: rtl/wsched_pick.sv
module wsched_pick
  import wsched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 16,
  parameter int unsigned AGE_W     = 4
) (
  input  logic [NUM_WARPS-1:0]          elig_i,
  input  logic [NUM_WARPS*AGE_W-1:0]    age_i,
  output logic                          any_o,
  output logic [idx_w(NUM_WARPS)-1:0]   warp_o
);
  localparam int unsigned WIDW = idx_w(NUM_WARPS);

  logic [AGE_W-1:0] best;

  // strict greater-than keeps the lower index on equal ages
  always_comb begin
    any_o  = 1'b0;
    warp_o = '0;
    best   = '0;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (elig_i[w] && (!any_o || (age_i[w*AGE_W +: AGE_W] > best))) begin
        any_o  = 1'b1;
        warp_o = WIDW'(w);
        best   = age_i[w*AGE_W +: AGE_W];
      end
    end
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 16,
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned INSTR_W   = 16,
  parameter int unsigned DISPATCH  = 4,
  parameter int unsigned AGE_W     = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_WARPS-1:0]                instr_valid_i,
  input  logic [NUM_WARPS*INSTR_W-1:0]        instr_i,
  input  logic                                wb_valid_i,
  input  logic [idx_w(NUM_WARPS)-1:0]         wb_warp_i,
  input  logic [idx_w(NUM_REGS)-1:0]          wb_reg_i,
  output logic                                issue_valid_o,
  output logic [idx_w(DISPATCH)-1:0]          issue_beat_o,
  output logic [idx_w(NUM_WARPS)-1:0]         issue_warp_o,
  output logic [INSTR_W-1:0]                  issue_instr_o
);
  localparam int unsigned WIDW = idx_w(NUM_WARPS);
  localparam int unsigned BW   = idx_w(DISPATCH);
  localparam logic [BW-1:0] LAST_BEAT = BW'(DISPATCH - 1);

  logic [NUM_WARPS-1:0]          elig_w;
  logic [NUM_WARPS*NUM_REGS-1:0] pend_w;
  logic [NUM_WARPS*AGE_W-1:0]    age_w;
  logic                          pick_any;
  logic [WIDW-1:0]               pick_warp;
  logic [INSTR_W-1:0]            pick_word;
  logic                          slot_free;
  logic                          grant;

  port_state_e        st_q;
  logic [BW-1:0]      beat_q;
  logic [WIDW-1:0]    warp_q;
  logic [INSTR_W-1:0] instr_q;

  wsched_scoreboard #(
    .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .INSTR_W(INSTR_W)
  ) sb_i (
    .clk(clk), .rst(rst),
    .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .wb_valid_i(wb_valid_i), .wb_warp_i(wb_warp_i), .wb_reg_i(wb_reg_i),
    .set_valid_i(grant), .set_warp_i(pick_warp),
    .elig_o(elig_w), .pend_o(pend_w)
  );

  wsched_age #(
    .NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)
  ) age_i (
    .clk(clk), .rst(rst),
    .instr_valid_i(instr_valid_i),
    .grant_valid_i(grant), .grant_warp_i(pick_warp),
    .age_o(age_w)
  );

  wsched_pick #(
    .NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)
  ) pick_i (
    .elig_i(elig_w), .age_i(age_w),
    .any_o(pick_any), .warp_o(pick_warp)
  );

  always_comb begin
    pick_word = '0;
    for (int w = 0; w < NUM_WARPS; w++) begin
      if (pick_warp == WIDW'(w)) pick_word = instr_i[w*INSTR_W +: INSTR_W];
    end
  end

  // the slot opens on the last beat, so the next warp follows with no gap
  assign slot_free = (st_q == PORT_IDLE) || (beat_q == LAST_BEAT);
  assign grant     = slot_free && pick_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PORT_IDLE;
      beat_q  <= '0;
      warp_q  <= '0;
      instr_q <= '0;
    end else if (grant) begin
      st_q    <= PORT_BUSY;
      beat_q  <= '0;
      warp_q  <= pick_warp;
      instr_q <= pick_word;
    end else if (slot_free) begin
      st_q    <= PORT_IDLE;
      beat_q  <= '0;
    end else begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign issue_valid_o = (st_q == PORT_BUSY);
  assign issue_beat_o  = beat_q;
  assign issue_warp_o  = warp_q;
  assign issue_instr_o = instr_q;

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int unsigned NUM_WARPS = 16,
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned INSTR_W   = 16,
  parameter int unsigned DISPATCH  = 4,
  parameter int unsigned WIDW      = 4,
  parameter int unsigned RW        = 3,
  parameter int unsigned BW        = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          issue_valid,
  input logic [BW-1:0]                 beat,
  input logic [WIDW-1:0]               warp,
  input logic [INSTR_W-1:0]            instr,
  input logic [NUM_WARPS-1:0]          elig,
  input logic [NUM_WARPS*NUM_REGS-1:0] pend
);
  localparam logic [BW-1:0] LAST = BW'(DISPATCH - 1);

  logic [NUM_WARPS-1:0] elig_d;
  always_ff @(posedge clk) begin
    if (rst) elig_d <= '0;
    else     elig_d <= elig;
  end

  // R7
  beat_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (beat != LAST)) |=>
      (issue_valid && (beat == BW'($past(beat) + 1'b1)) && $stable(warp) && $stable(instr)));

  // R7
  first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(issue_valid) |-> (beat == '0));

  // R2
  eligible_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (beat == '0)) |-> elig_d[warp]);

  // R3
  dest_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (beat == '0)) |-> pend[{warp, instr[RW-1:0]}]);

  // R8
  no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && (beat == LAST) && (|elig)) |=> (issue_valid && (beat == '0)));

  // R9
  idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
    ((!issue_valid || (beat == LAST)) && !(|elig)) |=> !issue_valid);

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .INSTR_W(INSTR_W),
  .DISPATCH(DISPATCH), .WIDW(WIDW), .RW(wsched_pkg::idx_w(NUM_REGS)), .BW(BW)
) chk_i (
  .clk(clk), .rst(rst),
  .issue_valid(issue_valid_o), .beat(issue_beat_o),
  .warp(issue_warp_o), .instr(issue_instr_o),
  .elig(elig_w), .pend(pend_w)
);

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;
  localparam int NW = 16, NR = 8, IW = 16, DISP = 4, AGE_W = 4;
  localparam int WIDW = 4, RW = 3, BW = 2, AGE_MAX = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst;
  logic [NW-1:0]        iv;
  logic [NW*IW-1:0]     iw;
  logic                 wb_valid;
  logic [WIDW-1:0]      wb_warp;
  logic [RW-1:0]        wb_reg;
  logic                 issue_valid_o;
  logic [BW-1:0]        issue_beat_o;
  logic [WIDW-1:0]      issue_warp_o;
  logic [IW-1:0]        issue_instr_o;

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .INSTR_W(IW), .DISPATCH(DISP), .AGE_W(AGE_W)) dut_i (
    .clk(clk), .rst(rst), .instr_valid_i(iv), .instr_i(iw),
    .wb_valid_i(wb_valid), .wb_warp_i(wb_warp), .wb_reg_i(wb_reg),
    .issue_valid_o(issue_valid_o), .issue_beat_o(issue_beat_o),
    .issue_warp_o(issue_warp_o), .issue_instr_o(issue_instr_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  // instruction source
  logic [IW-1:0] prog [NW][8];
  int plen [NW];
  int prd  [NW];

  // reference model
  bit            mpend [NW][NR];
  int            mage  [NW];
  bit            mval;
  int            mbeat, mwarp;
  logic [IW-1:0] minstr;
  int            exp_warp [$];
  logic [IW-1:0] exp_instr [$];
  int            order [$];
  int            vcycles;

  function automatic logic [IW-1:0] mk(input int d, input int a, input int b, input int tag);
    return {7'(tag), 3'(b), 3'(a), 3'(d)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int w, input logic [IW-1:0] x);
    prog[w][plen[w]] = x;
    plen[w]++;
  endtask

  // monitor: compares the port against the model and pops predicted issues
  task automatic monitor();
    int ew;
    logic [IW-1:0] ei;
    chk(issue_valid_o == mval, cur_req, "issue_valid", int'(issue_valid_o), int'(mval));
    if (issue_valid_o) begin
      vcycles++;
      chk(int'(issue_beat_o) == mbeat, "R7", "beat", int'(issue_beat_o), mbeat);
      if (issue_beat_o == '0) begin
        order.push_back(int'(issue_warp_o));
        if (exp_warp.size() == 0) chk(1'b0, "R10", "unpredicted issue", int'(issue_warp_o), -1);
        else begin
          ew = exp_warp.pop_front();
          ei = exp_instr.pop_front();
          chk(int'(issue_warp_o) == ew, "R10", "warp", int'(issue_warp_o), ew);
          chk(issue_instr_o == ei, "R10", "instr", int'(issue_instr_o), int'(ei));
        end
      end else begin
        chk(int'(issue_warp_o) == mwarp, "R7", "held warp", int'(issue_warp_o), mwarp);
        chk(issue_instr_o == minstr, "R7", "held instr", int'(issue_instr_o), int'(minstr));
      end
    end
  endtask

  // expected next state from the requirements; pushes predicted issues
  task automatic model_next(input bit wv, input int ww, input int wr);
    bit eff [NW][NR];
    int win, best;
    bit free;
    logic [IW-1:0] wd;
    eff = mpend;
    if (wv) eff[ww][wr] = 1'b0;
    win = -1; best = -1;
    for (int w = 0; w < NW; w++) begin
      if (iv[w]) begin
        wd = iw[w*IW +: IW];
        if (!eff[w][wd[2:0]] && !eff[w][wd[5:3]] && !eff[w][wd[8:6]] && mage[w] > best) begin
          win = w; best = mage[w];
        end
      end
    end
    free = !mval || (mbeat == DISP-1);
    if (!free) win = -1;
    for (int w = 0; w < NW; w++) begin
      if (!iv[w] || w == win) mage[w] = 0;
      else if (mage[w] < AGE_MAX) mage[w]++;
    end
    if (win >= 0) begin
      wd = iw[win*IW +: IW];
      mval = 1; mbeat = 0; mwarp = win; minstr = wd;
      eff[win][wd[2:0]] = 1'b1;
      exp_warp.push_back(win);
      exp_instr.push_back(wd);
    end else if (free) begin
      mval = 0; mbeat = 0;
    end else begin
      mbeat++;
    end
    mpend = eff;
  endtask

  // driver: one clock, entered and left at a falling edge
  task automatic step(input bit wv = 0, input int ww = 0, input int wr = 0);
    monitor();
    if (issue_valid_o && issue_beat_o == '0) prd[issue_warp_o]++;
    for (int w = 0; w < NW; w++) begin
      iv[w] = (prd[w] < plen[w]);
      iw[w*IW +: IW] = iv[w] ? prog[w][prd[w]] : '0;
    end
    wb_valid = wv; wb_warp = WIDW'(ww); wb_reg = RW'(wr);
    model_next(wv, ww, wr);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check_order(input string req, input int a, input int b, input int c);
    chk(order.size() >= 3, req, "issue count", order.size(), 3);
    if (order.size() >= 3) begin
      chk(order[0] == a, req, "first warp", order[0], a);
      chk(order[1] == b, req, "second warp", order[1], b);
      chk(order[2] == c, req, "third warp", order[2], c);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      plen[w] = 0; prd[w] = 0; mage[w] = 0;
      for (int r = 0; r < NR; r++) mpend[w][r] = 1'b0;
    end
    mval = 0; mbeat = 0; mwarp = 0; minstr = '0;
    rst = 1'b1; iv = '1; iw = '0; wb_valid = 0; wb_warp = '0; wb_reg = '0;
    repeat (3) @(negedge clk);
    // R1: every warp valid and ready, yet reset keeps the port idle
    chk(issue_valid_o == 1'b0, "R1", "valid in reset", int'(issue_valid_o), 0);
    iv = '0;
    rst = 1'b0;
    step();
    chk(issue_valid_o == 1'b0, "R1", "valid after reset", int'(issue_valid_o), 0);

    // R7 R8 R10: one warp, three independent instructions back to back
    cur_req = "R8";
    load(3, mk(1, 0, 0, 11)); load(3, mk(2, 0, 0, 12)); load(3, mk(3, 0, 0, 13));
    vcycles = 0;
    run(16);
    chk(vcycles == 3*DISP, "R8", "busy cycles", vcycles, 3*DISP);
    step(1, 3, 1); step(1, 3, 2); step(1, 3, 3);

    // R2 R9 R3: read-after-write stall, then released by a bypassed writeback
    cur_req = "R2";
    load(0, mk(4, 0, 0, 21)); load(0, mk(5, 4, 0, 22));
    vcycles = 0;
    run(10);
    chk(vcycles == DISP, "R2", "dependent held", vcycles, DISP);
    chk(issue_valid_o == 1'b0, "R9", "idle port", int'(issue_valid_o), 0);
    cur_req = "R3";
    step(1, 0, 4);
    chk(issue_valid_o == 1'b1 && issue_beat_o == '0 && issue_warp_o == 4'd0, "R3",
        "issue right after writeback", int'(issue_valid_o), 1);
    run(6);
    step(1, 0, 5);

    // R11: pending state is per warp
    cur_req = "R11";
    order.delete();
    load(1, mk(6, 0, 0, 31)); load(1, mk(0, 6, 0, 32));
    load(2, mk(7, 6, 6, 33));
    vcycles = 0;
    run(12);
    chk(vcycles == 2*DISP, "R11", "other warp not blocked", vcycles, 2*DISP);
    chk(order.size() == 2 && order[0] == 1 && order[1] == 2, "R11", "order head", order.size(), 2);
    step(1, 2, 6);
    step();
    chk(issue_valid_o == 1'b0, "R11", "foreign writeback ignored", int'(issue_valid_o), 0);
    step(1, 1, 6);
    run(6);
    step(1, 1, 0); step(1, 2, 7);

    // R6: equal ages resolve to the lowest index
    cur_req = "R6";
    order.delete();
    load(12, mk(1, 0, 0, 41)); load(9, mk(1, 0, 0, 42)); load(5, mk(1, 0, 0, 43));
    run(16);
    check_order("R6", 5, 9, 12);
    step(1, 5, 1); step(1, 9, 1); step(1, 12, 1);

    // R5: an older higher-index warp beats a younger lower-index one
    cur_req = "R5";
    order.delete();
    load(7, mk(2, 0, 0, 51)); load(12, mk(2, 0, 0, 52));
    step(); step();
    load(4, mk(2, 0, 0, 53));
    run(16);
    check_order("R5", 7, 12, 4);
    step(1, 7, 2); step(1, 12, 2); step(1, 4, 2);

    // R5: saturated ages tie, lower index wins over the longer waiter
    order.delete();
    load(14, mk(2, 0, 0, 61)); load(14, mk(1, 2, 0, 62));
    step(); step();
    load(13, mk(2, 0, 0, 63)); load(13, mk(1, 2, 0, 64));
    run(30);
    order.delete();
    load(0, mk(3, 0, 0, 65));
    step();
    step(1, 14, 2);
    step(1, 13, 2);
    run(12);
    check_order("R5", 0, 13, 14);
    step(1, 0, 3); step(1, 13, 1); step(1, 14, 1);

    // R4: writeback and issue to the same warp register in one cycle
    cur_req = "R4";
    load(6, mk(5, 0, 0, 71)); load(6, mk(5, 0, 0, 72)); load(6, mk(1, 5, 0, 73));
    vcycles = 0;
    run(8);
    chk(vcycles == DISP, "R4", "write-after-write held", vcycles, DISP);
    step(1, 6, 5);
    run(8);
    chk(vcycles == 2*DISP, "R4", "register stays pending", vcycles, 2*DISP);
    chk(issue_valid_o == 1'b0, "R4", "reader stalled", int'(issue_valid_o), 0);
    step(1, 6, 5);
    run(6);
    chk(vcycles == 3*DISP, "R4", "reader released", vcycles, 3*DISP);
    chk(exp_warp.size() == 0, "R10", "predicted issues left", exp_warp.size(), 0);

    finish_run();
  end

endmodule